// File: doc/BRIEF.md
# Pulse-Width Command Frame Receiver

This block sits on the card side of a 13.56 MHz proximity link and turns the reader's pulse-width coded commands into descrambled frames. Its input is the demodulated field envelope, where high means carrier present and low means a pause. All timing is counted in ticks of a 212 kHz enable strobe. Each symbol runs from the start of one pause to the start of the next. The symbol's length in ticks decides whether it is a 0 or a 1. A symbol that is too short, or one that runs too long, is a code violation. The protocol has no length field and no delimiter, so a violation is the only way a frame can end.

A controller pulses `arm` to begin a reception. While the receiver waits for the first pause, it keeps an external keystream generator in step, one advance per bit period. It then collects bits least significant first, XORs each bit with the current keystream bit, and advances the keystream after every accepted bit. At the violation it reports the frame, its length and an end timestamp. The controller uses that timestamp to place the card's reply. If the length is outside the legal window, or no frame starts in time, the receiver reports an error instead.

Top module: `pwc_frame_rx`

## Requirements
- R1: After reset, `frame_valid`, `frame_err` and `ks_adv` are low, and `frame_data`, `frame_len` and `frame_end_ts` are zero.
- R2: A one-cycle `arm` pulse starts a search for the first pause. `ks_adv` pulses once at the start of the search and once more at every 21st tick while no pause has been seen. If 40 bit periods (840 ticks) pass with no pause, `frame_err` pulses and the receiver returns to idle, for a total of 40 advances.
- R3: A symbol's duration is the number of ticks from the start of one pause to the start of the next. A duration greater than 17 decodes as 1. A duration of 17 or less, down to 4, decodes as 0.
- R4: A symbol shorter than 4 ticks is a code violation. It is also a code violation when 32 ticks pass from the symbol's start without the pause ending, or without the next pause arriving.
- R5: Accepted bit i is stored at `frame_data[i]` as the decoded bit XOR `ks_bit`. `ks_adv` pulses once after each accepted bit. The bits of `frame_data` at and above `frame_len` are zero.
- R6: A code violation after 6 to 23 accepted bits ends the frame. `frame_valid` pulses for exactly one cycle, and `frame_len` gives the bit count.
- R7: A code violation after fewer than 6 or more than 23 bits produces a one-cycle `frame_err` and no `frame_valid`. `frame_valid` and `frame_err` are never high together.
- R8: The timestamp is a 16-bit count of `tick_en` since reset that wraps around. `frame_end_ts` equals the count at the most recent pause start seen in the frame, plus 2 (the 4-tick pause length minus 2 ticks of pipeline compensation). The timestamp outputs change only together with `frame_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| env_in | input | 1 | Asynchronous demodulated envelope, 1 = carrier, 0 = pause |
| tick_en | input | 1 | One-cycle strobe at the 212 kHz tick rate |
| arm | input | 1 | One-cycle pulse that starts a reception from idle |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | One-cycle request to advance the keystream |
| frame_valid | output | 1 | One-cycle pulse when a legal frame ends |
| frame_err | output | 1 | One-cycle pulse on a bad frame length or a start timeout |
| frame_data | output | 23 | Descrambled frame bits, first received bit at bit 0 |
| frame_len | output | 5 | Number of bits in the frame |
| frame_end_ts | output | 16 | Compensated tick timestamp of the frame end |

## Verification
The bench targets the decision boundaries. It sends symbols of 17 and 18 ticks, where a threshold that is off by one would flip a bit. It sends 4 and 31 ticks, which are legal, and 3 and 32 ticks, which are violations; a wrong limit would either end frames too early or swallow a violation. It tests frame lengths of 5, 6, 23 and 24. It also places a pause at tick 839 and then leaves none until past 840, which catches a search timeout that fires a period early or late. Either error would shift the keystream and corrupt every bit that follows. Finally, each of the three ways a frame can end is checked against the expected timestamp, which catches a design that stamps the wrong pause or leaves out the compensation.

// File: rtl/pwc_rx_pkg.sv
package pwc_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HUNT = 2'd1,
        RX_LOW  = 2'd2,
        RX_HIGH = 2'd3
    } rx_state_e;

endpackage

// File: rtl/pwc_env_sync.sv
module pwc_env_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic env_async,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              last_d, last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign chain_d[g] = env_async;
            end else begin : g_next
                assign chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    assign last_d = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            last_q  <= last_d;
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~last_q;
    assign fall  = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/pwc_stamp_ctr.sv
module pwc_stamp_ctr #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    output logic [TS_W-1:0] stamp
);
    logic [TS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_en) begin
            cnt_d = cnt_q + TS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign stamp = cnt_q;
endmodule

// File: rtl/pwc_sym_judge.sv
module pwc_sym_judge #(
    parameter int SYM_W     = 6,
    parameter int THRESH    = 17,
    parameter int MIN_SYM   = 4,
    parameter int LIMIT     = 31
) (
    input  logic [SYM_W-1:0] dur,
    output logic             is_one,
    output logic             too_short,
    output logic             at_limit
);
    assign is_one    = (dur > SYM_W'(THRESH));
    assign too_short = (dur < SYM_W'(MIN_SYM));
    assign at_limit  = (dur >= SYM_W'(LIMIT));
endmodule

// File: rtl/pwc_frame_rx.sv
module pwc_frame_rx
    import pwc_rx_pkg::*;
#(
    parameter int TS_W         = 16,
    parameter int BIT_TICKS    = 21,
    parameter int ZERO_TICKS   = 13,
    parameter int PAUSE_TICKS  = 4,
    parameter int HUNT_PERIODS = 40,
    parameter int MIN_LEN      = 6,
    parameter int MAX_LEN      = 23,
    parameter int PIPE_COMP    = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int LEN_W        = $clog2(MAX_LEN + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               env_in,
    input  logic               tick_en,
    input  logic               arm,
    input  logic               ks_bit,
    output logic               ks_adv,
    output logic               frame_valid,
    output logic               frame_err,
    output logic [MAX_LEN-1:0] frame_data,
    output logic [LEN_W-1:0]   frame_len,
    output logic [TS_W-1:0]    frame_end_ts
);
    localparam int THRESH = (ZERO_TICKS + BIT_TICKS) / 2;
    localparam int LIMIT  = (BIT_TICKS * 3) / 2;
    localparam int SYM_W  = $clog2(LIMIT + 2);
    localparam int HC_W   = $clog2(BIT_TICKS);
    localparam int PER_W  = $clog2(HUNT_PERIODS + 1);
    localparam int LEN_MAXV = (1 << LEN_W) - 1;

    typedef struct packed {
        rx_state_e          st;
        logic [HC_W-1:0]    hcnt;
        logic [PER_W-1:0]   per;
        logic [SYM_W-1:0]   sym;
        logic [LEN_W-1:0]   len;
        logic [MAX_LEN-1:0] shreg;
        logic [TS_W-1:0]    pts;
        logic               adv;
        logic               vld;
        logic               err;
        logic [MAX_LEN-1:0] odata;
        logic [LEN_W-1:0]   olen;
        logic [TS_W-1:0]    ots;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic            env_lvl, env_rise, env_fall;
    logic [TS_W-1:0] stamp;
    logic            sym_one, sym_short, sym_limit;

    pwc_env_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .env_async (env_in),
        .level     (env_lvl),
        .rise      (env_rise),
        .fall      (env_fall)
    );

    pwc_stamp_ctr #(.TS_W(TS_W)) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .stamp   (stamp)
    );

    pwc_sym_judge #(
        .SYM_W   (SYM_W),
        .THRESH  (THRESH),
        .MIN_SYM (PAUSE_TICKS),
        .LIMIT   (LIMIT)
    ) u_judge (
        .dur       (r_q.sym),
        .is_one    (sym_one),
        .too_short (sym_short),
        .at_limit  (sym_limit)
    );

    logic violate;
    logic sym_tick;

    always_comb begin
        r_d     = r_q;
        r_d.adv = 1'b0;
        r_d.vld = 1'b0;
        r_d.err = 1'b0;
        violate = 1'b0;

        // symbol timer runs while a symbol is open, held at its limit
        sym_tick = tick_en && !sym_limit &&
                   (r_q.st == RX_LOW || r_q.st == RX_HIGH);
        if (sym_tick) begin
            r_d.sym = r_q.sym + SYM_W'(1);
        end

        unique case (r_q.st)
            RX_IDLE: begin
                if (arm) begin
                    r_d.st    = RX_HUNT;
                    r_d.hcnt  = '0;
                    r_d.per   = '0;
                    r_d.len   = '0;
                    r_d.shreg = '0;
                    r_d.adv   = 1'b1;
                end
            end

            RX_HUNT: begin
                if (env_fall) begin
                    r_d.st  = RX_LOW;
                    r_d.sym = '0;
                    r_d.pts = stamp;
                end else if (tick_en) begin
                    if (r_q.hcnt == HC_W'(BIT_TICKS - 1)) begin
                        r_d.hcnt = '0;
                        if (r_q.per == PER_W'(HUNT_PERIODS - 1)) begin
                            r_d.st  = RX_IDLE;
                            r_d.err = 1'b1;
                        end else begin
                            r_d.per = r_q.per + PER_W'(1);
                            r_d.adv = 1'b1;
                        end
                    end else begin
                        r_d.hcnt = r_q.hcnt + HC_W'(1);
                    end
                end
            end

            RX_LOW: begin
                if (env_rise) begin
                    r_d.st = RX_HIGH;
                end else if (tick_en && sym_limit) begin
                    violate = 1'b1;
                end
            end

            RX_HIGH: begin
                if (env_fall) begin
                    r_d.pts = stamp;
                    r_d.sym = '0;
                    if (sym_short) begin
                        violate = 1'b1;
                    end else begin
                        r_d.st  = RX_LOW;
                        r_d.adv = 1'b1;
                        if (r_q.len < LEN_W'(MAX_LEN)) begin
                            r_d.shreg[r_q.len] = sym_one ^ ks_bit;
                        end
                        if (r_q.len != LEN_W'(LEN_MAXV)) begin
                            r_d.len = r_q.len + LEN_W'(1);
                        end
                    end
                end else if (tick_en && sym_limit) begin
                    violate = 1'b1;
                end
            end

            default: r_d.st = RX_IDLE;
        endcase

        if (violate) begin
            r_d.st = RX_IDLE;
            if (r_q.len >= LEN_W'(MIN_LEN) && r_q.len <= LEN_W'(MAX_LEN)) begin
                r_d.vld   = 1'b1;
                r_d.odata = r_q.shreg;
                r_d.olen  = r_q.len;
                r_d.ots   = r_d.pts + TS_W'(PAUSE_TICKS - PIPE_COMP);
            end else begin
                r_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: RX_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ks_adv       = r_q.adv;
    assign frame_valid  = r_q.vld;
    assign frame_err    = r_q.err;
    assign frame_data   = r_q.odata;
    assign frame_len    = r_q.olen;
    assign frame_end_ts = r_q.ots;

    logic unused_lvl;
    assign unused_lvl = env_lvl;
endmodule

// File: rtl/pwc_frame_rx_chk.sv
module pwc_frame_rx_chk #(
    parameter int MIN_LEN = 6,
    parameter int MAX_LEN = 23,
    parameter int LEN_W   = 5,
    parameter int TS_W    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_valid,
    input logic               frame_err,
    input logic [MAX_LEN-1:0] frame_data,
    input logic [LEN_W-1:0]   frame_len,
    input logic [TS_W-1:0]    frame_end_ts
);
    a_r6_len_window: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_len >= LEN_W'(MIN_LEN) && frame_len <= LEN_W'(MAX_LEN)));

    a_r6_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && frame_err));

    a_r7_single_err: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ((frame_data >> frame_len) == '0));

    a_r8_ts_moves_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_end_ts) |-> frame_valid);
endmodule

bind pwc_frame_rx pwc_frame_rx_chk #(
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W),
    .TS_W    (TS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_valid  (frame_valid),
    .frame_err    (frame_err),
    .frame_data   (frame_data),
    .frame_len    (frame_len),
    .frame_end_ts (frame_end_ts)
);

// File: tb/tb_pwc_frame_rx.sv
module tb_pwc_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        env_in = 1'b1;
    logic        arm = 1'b0;
    logic        tick_en;
    logic        ks_bit;
    logic        ks_adv;
    logic        frame_valid, frame_err;
    logic [22:0] frame_data;
    logic [4:0]  frame_len;
    logic [15:0] frame_end_ts;

    localparam logic [15:0] SEED = 16'hACE1;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0]  tdiv = 2'd0;
    int          tb_ticks = 0;
    logic [15:0] lfsr = SEED;
    int          adv_cnt = 0;
    int          got_v = 0, got_e = 0;
    int          durs [0:33];
    int          pts  [0:34];
    int          adv_first;

    always #10 clk = ~clk;

    pwc_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .env_in(env_in), .tick_en(tick_en),
        .arm(arm), .ks_bit(ks_bit), .ks_adv(ks_adv),
        .frame_valid(frame_valid), .frame_err(frame_err),
        .frame_data(frame_data), .frame_len(frame_len),
        .frame_end_ts(frame_end_ts)
    );

    assign tick_en = (tdiv == 2'd3);
    assign ks_bit  = lfsr[0];

    function automatic logic [15:0] lstep(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic ks_nth(input int n);
        logic [15:0] s = SEED;
        for (int k = 0; k < n; k++) s = lstep(s);
        return s[0];
    endfunction

    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        if (!rst_n) tb_ticks <= 0;
        else if (tick_en) tb_ticks <= tb_ticks + 1;
        if (arm) begin
            lfsr <= SEED;
            adv_cnt <= 0;
        end else if (ks_adv) begin
            lfsr <= lstep(lfsr);
            adv_cnt <= adv_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (frame_valid) got_v = got_v + 1;
        if (frame_err) got_e = got_e + 1;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_neg();
        do @(negedge clk); while (!tick_en);
    endtask

    task automatic hold(input int n);
        repeat (n) tick_neg();
    endtask

    // nsym symbols from durs[], then a closing pause: mode 0 carrier stays up,
    // mode 2 pause held past the limit
    task automatic send(input int w, input int nsym, input int mode);
        got_v = 0;
        got_e = 0;
        tick_neg();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        hold(w);
        for (int i = 0; i < nsym; i++) begin
            int pl;
            pl = (durs[i] >= 8) ? 4 : durs[i] / 2;
            pts[i] = tb_ticks + 1;
            env_in = 1'b0;
            hold(pl);
            env_in = 1'b1;
            if (i == 0) adv_first = adv_cnt;
            hold(durs[i] - pl);
        end
        pts[nsym] = tb_ticks + 1;
        env_in = 1'b0;
        hold(mode == 2 ? 40 : 4);
        env_in = 1'b1;
        hold(40);
        repeat (4) @(negedge clk);
    endtask

    // expected outcome from R3, R4, R6, R7, R8
    task automatic judge(input string tag, input int w, input int nsym);
        int len = nsym;
        int ts = pts[nsym];
        int a = 1 + w / 21;
        bit good;
        logic [22:0] exp_d = '0;
        for (int k = nsym - 1; k >= 0; k--) begin
            if (durs[k] > 31) begin len = k; ts = pts[k]; end
            else if (durs[k] < 4) begin len = k; ts = pts[k + 1]; end
        end
        for (int i = 0; i < len && i < 23; i++)
            exp_d[i] = (durs[i] > 17) ^ ks_nth(a + i);
        good = (len >= 6 && len <= 23);
        chk(adv_first == a, {tag, " R2 hunt advances"}, adv_first, a);
        chk(got_v == (good ? 1 : 0), {tag, " R6 valid count"}, got_v, good);
        chk(got_e == (good ? 0 : 1), {tag, " R7 err count"}, got_e, !good);
        if (good) begin
            chk(frame_len == len, {tag, " R6 len"}, frame_len, len);
            chk(frame_data == exp_d, {tag, " R5 data"}, frame_data, exp_d);
            chk(frame_end_ts == 16'((ts + 2) & 16'hFFFF), {tag, " R8 ts"},
                frame_end_ts, (ts + 2) & 16'hFFFF);
        end
    endtask

    task automatic nominal(input int n, input logic [31:0] bits);
        for (int i = 0; i < n; i++) durs[i] = bits[i] ? 21 : 13;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!frame_valid && !frame_err && !ks_adv, "R1 strobes low", {frame_valid, frame_err, ks_adv}, 0);
        chk(frame_data == 0 && frame_len == 0 && frame_end_ts == 0, "R1 outputs zero",
            frame_data, 0);

        // nominal 8-bit frame, carrier ends it (R3 R5 R6 R8)
        nominal(8, 32'hB5);
        send(10, 8, 0);
        judge("nominal", 10, 8);

        // threshold and limits: 17->0, 18->1, 4 and 31 legal (R3 R4)
        durs[0] = 17; durs[1] = 18; durs[2] = 4; durs[3] = 31;
        durs[4] = 13; durs[5] = 21; durs[6] = 17; durs[7] = 18;
        send(30, 8, 0);
        judge("bounds R3", 30, 8);

        // minimum length, ended by held pause (R4 R6)
        nominal(6, 32'h2A);
        send(5, 6, 2);
        judge("len6 R6", 5, 6);

        // maximum length, ended by a short symbol (R4 R6)
        nominal(23, 32'h5A5A5A);
        durs[23] = 2;
        send(7, 24, 0);
        judge("len23 short R4", 7, 24);

        // too short and too long (R7)
        nominal(5, 32'h15);
        send(3, 5, 0);
        judge("len5 R7", 3, 5);
        nominal(24, 32'hFFF000);
        send(3, 24, 0);
        judge("len24 R7", 3, 24);

        // 32-tick symbol mid frame is a violation (R4)
        nominal(10, 32'h3C3);
        durs[7] = 32;
        send(12, 10, 0);
        judge("sym32 R4", 12, 10);

        // 3-tick symbol mid frame; and early, giving error (R4 R7)
        nominal(14, 32'h1F0F);
        durs[10] = 3;
        send(12, 14, 0);
        judge("sym3 R4", 12, 14);
        nominal(8, 32'hA5);
        durs[3] = 2;
        send(12, 8, 0);
        judge("early short R7", 12, 8);

        // latest legal first pause (R2)
        nominal(6, 32'h33);
        send(839, 6, 0);
        judge("hunt839 R2", 839, 6);

        // hunt timeout (R2)
        got_v = 0; got_e = 0;
        tick_neg();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        hold(845);
        repeat (4) @(negedge clk);
        chk(got_e == 1 && got_v == 0, "R2 hunt timeout err", got_e, 1);
        chk(adv_cnt == 40, "R2 hunt total advances", adv_cnt, 40);

        // random frames (R3 R5 R6 R8)
        for (int f = 0; f < 8; f++) begin
            int n = 6 + $urandom % 18;
            int w = 1 + $urandom % 100;
            int m = ($urandom % 2) * 2;
            for (int i = 0; i < n; i++)
                durs[i] = ($urandom % 2) ? 18 + $urandom % 14 : 4 + $urandom % 14;
            send(w, n, m);
            judge("random", w, n);
        end

        summary();
        $finish;
    end
endmodule